// File: doc/BRIEF.md
# Angle-to-Quadrature Encoder Emulator

This block turns an absolute angle word, such as the output of a resolver-to-digital tracking loop, into the signals an incremental encoder would produce. These are two quadrature phases, a once-per-turn index marker and a direction flag. Inside, an emulated position register chases the incoming angle. It moves by at most one least significant bit on each update tick and takes the shorter way round the circle. Because the phases come from the two low bits of that position, a 12-bit angle yields 1,024 full quadrature cycles per turn. A jump in the angle is therefore spread out as a train of single steps that a counter downstream can follow.

The update tick is a clock enable. In a typical system it is derived from a 4.096 MHz reference, so four ticks make one quadrature cycle. The direction flag does not follow the emulated position. It follows the sign of the most recent change of the input angle, so it can flip while the position has not moved at all. The outputs are never gated off: they always show the current emulated position.

Top module: `angle_quad_emu`

## Requirements
- R1: While `rst` is high on a clock edge, the emulated position loads `ang_in` directly with no stepping. `dir_up` goes to 1. `qa`, `qb` and `qz` show the loaded position from the following cycle.
- R2: The emulated position changes only on an edge where `upd_en` is 1, and then by exactly one LSB. With `upd_en` at 0, `qa` and `qb` hold their values.
- R3: The step direction is the shorter way round modulo 2^ANG_W. Let d = (`ang_in` − position) mod 2^ANG_W. If d is from 1 to 2^(ANG_W−1), the position steps up. A difference of exactly half a turn steps up. Any other nonzero d steps down.
- R4: The two low position bits 00, 01, 10, 11 give {`qa`,`qb`} = 00, 10, 11, 01. With a rising position, `qa` therefore leads `qb` by a quarter cycle, and with a falling position `qb` leads `qa`.
- R5: Each step changes exactly one of `qa` and `qb`. A cycle without a step changes neither.
- R6: `qz` is 1 exactly while the emulated position is zero. That is the quarter of a quadrature cycle where {`qa`,`qb`} = 00.
- R7: On an edge where `ang_in` differs from its value at the previous edge, `dir_up` becomes 1 if the shorter-way change is upward (a half-turn change counts as upward) and 0 otherwise. This happens whether or not `upd_en` is 1. On an edge where `ang_in` is unchanged, `dir_up` holds.
- R8: Once the position equals `ang_in`, further ticks leave `qa`, `qb` and `qz` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update tick, one clock wide |
| ang_in | input | ANG_W | Absolute angle word |
| qa | output | 1 | Quadrature phase A |
| qb | output | 1 | Quadrature phase B |
| qz | output | 1 | Once-per-turn index marker |
| dir_up | output | 1 | Direction of the latest input change, 1 for rising |

## Verification
The hardest cases to reach from the ports are the ones where the input and the emulated position disagree about where things are. In one, the angle jumps by exactly half a turn or one LSB more, so the step direction depends on the tie-break rule. In another, the angle dithers by one LSB while ticks are withheld, so `dir_up` flips repeatedly while the phases stand still. The stimulus builds both cases directly: it resets onto zero and then presents 2048 or 2049 for a single tick, and it toggles the angle between neighbouring values with `upd_en` held low. Ramps through zero in both directions, a long catch-up after a large jump, and random angles with sparse ticks then drive the per-clock model through the wrap and index cases.

// File: rtl/qenc_pkg.sv
`timescale 1ns/1ps
package qenc_pkg;

    localparam int ANGLE_BITS_DEFAULT = 12;

    typedef enum logic [1:0] {
        MOVE_HOLD = 2'd0,
        MOVE_UP   = 2'd1,
        MOVE_DOWN = 2'd2
    } move_e;

    typedef struct packed {
        logic a;
        logic b;
        logic z;
    } quad_s;

    // Gray-style phase: 00 -> 00, 01 -> 10, 10 -> 11, 11 -> 01 for {a,b}
    function automatic quad_s quad_from_phase(input logic [1:0] ph, input logic at_zero);
        quad_s q;
        q.a = ph[1] ^ ph[0];
        q.b = ph[1];
        q.z = at_zero;
        return q;
    endfunction

endpackage

// File: rtl/qenc_step_pick.sv
`timescale 1ns/1ps
module qenc_step_pick
    import qenc_pkg::*;
#(
    parameter int ANG_W = ANGLE_BITS_DEFAULT
) (
    input  logic [ANG_W-1:0] cur,
    input  logic [ANG_W-1:0] tgt,
    output move_e            mv
);
    localparam logic [ANG_W-1:0] HALF_TURN = ANG_W'(1) << (ANG_W - 1);

    logic [ANG_W-1:0] gap;

    always_comb begin
        gap = tgt - cur;
        if (gap == '0) begin
            mv = MOVE_HOLD;
        end else if (gap <= HALF_TURN) begin
            mv = MOVE_UP;
        end else begin
            mv = MOVE_DOWN;
        end
    end
endmodule

// File: rtl/qenc_pos_track.sv
`timescale 1ns/1ps
module qenc_pos_track
    import qenc_pkg::*;
#(
    parameter int ANG_W = ANGLE_BITS_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [ANG_W-1:0] ang,
    output logic [ANG_W-1:0] pos
);
    move_e mv;

    qenc_step_pick #(.ANG_W(ANG_W)) i_pick (
        .cur (pos),
        .tgt (ang),
        .mv  (mv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= ang;
        end else if (tick) begin
            case (mv)
                MOVE_UP:   pos <= pos + ANG_W'(1);
                MOVE_DOWN: pos <= pos - ANG_W'(1);
                default:   pos <= pos;
            endcase
        end
    end
endmodule

// File: rtl/qenc_dir_track.sv
`timescale 1ns/1ps
module qenc_dir_track
    import qenc_pkg::*;
#(
    parameter int ANG_W = ANGLE_BITS_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ANG_W-1:0] ang,
    output logic             dir_up
);
    logic [ANG_W-1:0] last_ang;
    move_e            sense;

    qenc_step_pick #(.ANG_W(ANG_W)) i_sense (
        .cur (last_ang),
        .tgt (ang),
        .mv  (sense)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_ang <= ang;
            dir_up   <= 1'b1;
        end else begin
            last_ang <= ang;
            case (sense)
                MOVE_UP:   dir_up <= 1'b1;
                MOVE_DOWN: dir_up <= 1'b0;
                default:   dir_up <= dir_up;
            endcase
        end
    end
endmodule

// File: rtl/qenc_phase_dec.sv
`timescale 1ns/1ps
module qenc_phase_dec
    import qenc_pkg::*;
#(
    parameter int ANG_W = ANGLE_BITS_DEFAULT
) (
    input  logic [ANG_W-1:0] pos,
    output quad_s            q
);
    logic at_zero;

    always_comb begin
        at_zero = (pos == '0);
        q       = quad_from_phase(pos[1:0], at_zero);
    end
endmodule

// File: rtl/angle_quad_emu.sv
`timescale 1ns/1ps
module angle_quad_emu
    import qenc_pkg::*;
#(
    parameter int ANG_W = ANGLE_BITS_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [ANG_W-1:0] ang_in,
    output logic             qa,
    output logic             qb,
    output logic             qz,
    output logic             dir_up
);
    logic [ANG_W-1:0] emu_pos;
    quad_s            phase;

    qenc_pos_track #(.ANG_W(ANG_W)) i_pos (
        .clk  (clk),
        .rst  (rst),
        .tick (upd_en),
        .ang  (ang_in),
        .pos  (emu_pos)
    );

    qenc_phase_dec #(.ANG_W(ANG_W)) i_dec (
        .pos (emu_pos),
        .q   (phase)
    );

    qenc_dir_track #(.ANG_W(ANG_W)) i_dir (
        .clk    (clk),
        .rst    (rst),
        .ang    (ang_in),
        .dir_up (dir_up)
    );

    assign qa = phase.a;
    assign qb = phase.b;
    assign qz = phase.z;
endmodule

// File: rtl/angle_quad_emu_chk.sv
`timescale 1ns/1ps
module angle_quad_emu_chk #(
    parameter int ANG_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             upd_en,
    input logic [ANG_W-1:0] ang_in,
    input logic             qa,
    input logic             qb,
    input logic             qz,
    input logic             dir_up
);
    // R1: reset forces the direction flag high
    a_r1_dir_after_reset: assert property (@(posedge clk)
        rst |=> dir_up);

    // R2: without a tick the phases stand still
    a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable({qa, qb}));

    // R5: at most one phase edge per clock
    a_r5_single_edge: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones({qa, qb} ^ $past({qa, qb})) <= 1));

    // R6: the index marker sits in the 00 phase state
    a_r6_index_phase: assert property (@(posedge clk) disable iff (rst)
        qz |-> (!qa && !qb));

    // R7: an unchanged angle leaves the direction flag alone
    a_r7_dir_hold: assert property (@(posedge clk) disable iff (rst)
        (ang_in == $past(ang_in)) |=> $stable(dir_up));
endmodule

bind angle_quad_emu angle_quad_emu_chk #(.ANG_W(ANG_W)) i_chk (
    .clk    (clk),
    .rst    (rst),
    .upd_en (upd_en),
    .ang_in (ang_in),
    .qa     (qa),
    .qb     (qb),
    .qz     (qz),
    .dir_up (dir_up)
);

// File: tb/test_angle_quad_emu.sv
`timescale 1ns/1ps
module test_angle_quad_emu;
    localparam int AW  = 12;
    localparam int MOD = 1 << AW;
    localparam int HLF = MOD / 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          upd_en;
    logic [AW-1:0] ang_in;
    logic          qa, qb, qz, dir_up;

    always #4 clk = ~clk;

    angle_quad_emu #(.ANG_W(AW)) i_angle_quad_emu (
        .clk(clk), .rst(rst), .upd_en(upd_en), .ang_in(ang_in),
        .qa(qa), .qb(qb), .qz(qz), .dir_up(dir_up)
    );

    int errs   = 0;
    int checks = 0;
    bit done   = 0;
    bit live   = 0;

    // behavioural reference
    int m_pos, m_prev, m_step, m_rst_last;
    bit m_dir;
    int exp_ab_prev;

    function automatic int ab_of(int p);
        int ph = p % 4;
        int a  = (ph == 1 || ph == 2) ? 1 : 0;
        int b  = (ph >= 2) ? 1 : 0;
        return a * 2 + b;
    endfunction

    always @(posedge clk) begin
        int d;
        m_step = 0;
        if (rst) begin
            m_pos = int'(ang_in);
            m_prev = int'(ang_in);
            m_dir = 1;
            m_rst_last = 1;
        end else begin
            m_rst_last = 0;
            if (int'(ang_in) != m_prev) begin
                d = (int'(ang_in) - m_prev + MOD) % MOD;
                m_dir = (d <= HLF);
            end
            m_prev = int'(ang_in);
            if (upd_en && m_pos != int'(ang_in)) begin
                d = (int'(ang_in) - m_pos + MOD) % MOD;
                m_pos = (d <= HLF) ? (m_pos + 1) % MOD : (m_pos + MOD - 1) % MOD;
                m_step = 1;
            end
        end
        live = 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        int ab, flips, x;
        if (live && !done) begin
            ab = {30'd0, qa, qb};
            chk("R4 R2 R3 phase pair", ab, ab_of(m_pos));
            chk("R6 index marker", int'(qz), (m_pos == 0) ? 1 : 0);
            chk("R7 direction", int'(dir_up), int'(m_dir));
            if (!m_rst_last && !rst) begin
                x = ab ^ exp_ab_prev;
                flips = (x & 1) + ((x >> 1) & 1);
                chk("R5 edges per step", flips, m_step);
            end
            exp_ab_prev = ab_of(m_pos);
        end
    end

    task automatic drive(input int a, input bit e);
        ang_in = AW'(a);
        upd_en = e;
        @(negedge clk);
    endtask

    task automatic do_reset(input int a);
        rst = 1'b1;
        drive(a, 0);
        drive(a, 0);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        upd_en = 1'b0;
        ang_in = '0;

        // R1: reset onto 6 gives phase 10 -> {qa,qb}=11, dir high
        do_reset(6);
        chk("R1 qa after reset", int'(qa), 1);
        chk("R1 qb after reset", int'(qb), 1);
        chk("R1 qz after reset", int'(qz), 0);
        chk("R1 dir after reset", int'(dir_up), 1);
        do_reset(0);
        chk("R1 qz at zero", int'(qz), 1);

        // R3: half turn from 0 steps up to 1 -> {qa,qb}=10
        drive(HLF, 1);
        chk("R3 half-turn step up qa", int'(qa), 1);
        chk("R3 half-turn step up qb", int'(qb), 0);
        chk("R7 half-turn dir up", int'(dir_up), 1);
        do_reset(0);
        // R3: one past half steps down to 4095 -> {qa,qb}=01
        drive(HLF + 1, 1);
        chk("R3 past-half step down qa", int'(qa), 0);
        chk("R3 past-half step down qb", int'(qb), 1);
        chk("R7 past-half dir down", int'(dir_up), 0);

        // R2: large gap but no ticks: phases hold
        do_reset(100);
        for (int i = 0; i < 12; i++) begin
            drive(900, 0);
            chk("R2 hold without tick", {30'd0, qa, qb}, ab_of(100));
        end

        // catch-up after a large jump
        for (int i = 0; i < 820; i++) drive(900, 1);
        // R8: settled, further ticks change nothing
        for (int i = 0; i < 10; i++) begin
            drive(900, 1);
            chk("R8 settled phases", {30'd0, qa, qb}, ab_of(900));
        end

        // slow ramp up through zero
        do_reset(4080);
        for (int s = 4080; s < 4080 + 40; s++) begin
            for (int k = 0; k < 3; k++) drive(s % MOD, 1);
        end
        // ramp down through zero
        for (int s = 4120; s > 4040; s--) begin
            for (int k = 0; k < 2; k++) drive(s % MOD, 1);
        end

        // R7: one-LSB dither without ticks flips dir every clock
        for (int i = 0; i < 16; i++) begin
            drive((i % 2 == 0) ? 2 : 1, 0);
            chk("R7 dither dir", int'(dir_up), (i % 2 == 0) ? 1 : 0);
        end
        // dither across zero
        for (int i = 0; i < 16; i++) drive((i % 2 == 0) ? 0 : MOD - 1, i % 3 == 0);

        // random angles with sparse ticks
        for (int i = 0; i < 60; i++) begin
            int t = int'($urandom_range(MOD - 1, 0));
            for (int k = 0; k < 60; k++) drive(t, (k % 3) == 0);
        end
        // random walk with a tick every clock
        begin
            int w = 2000;
            for (int i = 0; i < 3000; i++) begin
                w = (w + int'($urandom_range(6, 0)) - 3 + MOD) % MOD;
                drive(w, 1);
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule